// File: doc/BRIEF.md
# MSI Event Queue Controller

This block accepts message-signalled interrupt writes that an upstream transaction layer has already decoded. Each write carries an MSI number, a requester ID, a format/type code, a length, an address and a second data word. The block looks the MSI number up in a mapping table that names a target event queue. If every acceptance condition holds, it emits a 128-bit entry (two 64-bit words), together with the queue number and the ring slot it belongs in, for an external memory writer. It then advances that queue's tail pointer.

Each mapping entry has a blocking latch. The latch is set when an entry is accepted and is released only by software, so a second write of the same MSI number is suppressed until the first has been serviced. Every queue keeps a head pointer, a tail pointer, an enable bit, an overflow flag and a one-hot state of idle, active or error, and drives one interrupt request line. Software reads entries from memory and then writes the head pointer forward.

Top module: `msiq_ctrl`

## Requirements
- R1: After reset every queue reads state 3'b001 (idle), head 0 and tail 0, and is disabled with overflow clear. Every mapping entry is invalid with its latch clear. `irq` and `ent_we` are low.
- R2: A write is accepted only when all of these hold:
  - `msi_fmt[6:3]` is 4'hb or 4'hf;
  - `msi_num` is below NUM_MSI;
  - the mapping valid bit (bit 63) is set;
  - the 6-bit target (bits 5:0) is below NUM_Q;
  - the target queue is enabled and not in error;
  - the latch is clear.
  A write that fails any condition produces no entry.
- R3: For an accepted write, `ent_we` is high in the cycle after `msi_valid`. In that cycle `ent_queue` is the target queue and `ent_index` is the old tail. `ent_word0` is {0, fmt[6:0], len[9:0], addr[15:2], rid[15:0], num[15:0]}. `ent_word1` is {addr[63:16], data1[15:0]}.
- R4: Accepting a write sets the latch, which reads back at bit 62 of the mapping register. While the latch is set, the same MSI number is dropped. Writing a 1 to bit 62 of that MSI's release register clears the latch.
- R5: Each accepted entry advances the queue tail by one, and the tail wraps from 2^DEPTH_W-1 to 0.
- R6: If tail+1 equals head, the write is dropped. Overflow is then set, reading back at bit 57 of the tail and control registers, and the state becomes 3'b100 (error). The dropped write leaves its latch clear, and a queue in error accepts nothing.
- R7: Writing bit 44 to a queue's control-set register enables the queue. Writing bit 44 to its control-clear register disables it and forces the state to idle. Writing bit 57 to the control-clear register clears overflow and moves an error queue to idle if head equals tail, or to active otherwise.
- R8: An idle queue becomes active (3'b010) when it accepts an entry. An active queue returns to idle in the cycle in which a head or tail write makes head equal tail.
- R9: `irq[q]` is high exactly while queue q is enabled and its head differs from its tail.
- R10: The register address is {space[2:0], index}, with these spaces:
  - 0: mapping, read/write;
  - 1: latch release, write only;
  - 2: control set;
  - 3: control clear;
  - 4: state;
  - 5: tail, read/write;
  - 6: head, read/write.
  Control reads return enable at bit 44 and overflow at bit 57. `reg_rdata` is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | Decoded MSI write present this cycle |
| msi_num | input | 16 | MSI number (first data field) |
| msi_fmt | input | 7 | Format/type code |
| msi_len | input | 10 | Length field |
| msi_rid | input | 16 | Requester ID |
| msi_addr | input | 64 | Write address |
| msi_data1 | input | 16 | Second data field |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | {space, index} register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| ent_we | output | 1 | Entry write request |
| ent_queue | output | QIW | Target queue of the entry |
| ent_index | output | DEPTH_W | Ring slot of the entry |
| ent_word0 | output | 64 | Entry word 0 |
| ent_word1 | output | 64 | Entry word 1 |
| irq | output | NUM_Q | Per-queue interrupt request |

## Verification
The assertions check the following on every cycle:
- each queue state stays one-hot;
- a latched or unmapped MSI never yields an entry;
- every emitted entry leaves its latch set and went to a queue that was enabled;
- a rising overflow always coincides with the error state.

Only the bench scenarios can show:
- exact entry contents and slot numbers across a sweep of all MSIs;
- the ring wrap and the exact capacity at which overflow occurs;
- recovery from error;
- the return to idle once the head catches the tail.

// File: rtl/msiq_pkg.sv
package msiq_pkg;

  typedef enum logic [2:0] {
    QS_IDLE   = 3'b001,
    QS_ACTIVE = 3'b010,
    QS_ERROR  = 3'b100
  } qstate_e;

  localparam logic [2:0] SP_MAP   = 3'd0;
  localparam logic [2:0] SP_REL   = 3'd1;
  localparam logic [2:0] SP_CSET  = 3'd2;
  localparam logic [2:0] SP_CCLR  = 3'd3;
  localparam logic [2:0] SP_STATE = 3'd4;
  localparam logic [2:0] SP_TAIL  = 3'd5;
  localparam logic [2:0] SP_HEAD  = 3'd6;

  localparam int B_VALID = 63;
  localparam int B_LATCH = 62;
  localparam int B_OVF   = 57;
  localparam int B_EN    = 44;

  // Only the two MSI types are queued.
  function automatic logic is_msi_type(input logic [6:0] ft);
    return (ft[6:3] == 4'hb) || (ft[6:3] == 4'hf);
  endfunction

  function automatic logic [63:0] pack_word0(input logic [6:0] ft, input logic [9:0] len,
                                             input logic [13:0] alo, input logic [15:0] rid,
                                             input logic [15:0] num);
    return {1'b0, ft, len, alo, rid, num};
  endfunction

  function automatic logic [63:0] pack_word1(input logic [47:0] ahi, input logic [15:0] d1);
    return {ahi, d1};
  endfunction

endpackage

// File: rtl/msiq_map_table.sv
module msiq_map_table #(
  parameter int NUM_MSI = 16,
  parameter int IW      = 4,
  parameter int MW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_map,
  input  logic               wr_rel,
  input  logic [IW-1:0]      wr_idx,
  input  logic               wr_valid_bit,
  input  logic [5:0]         wr_target,
  input  logic               wr_rel_bit,
  input  logic               set_latch,
  input  logic [MW-1:0]      set_num,
  output logic [NUM_MSI-1:0] map_valid,
  output logic [NUM_MSI-1:0] map_latch,
  output logic [5:0]         map_target [NUM_MSI]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_valid <= '0;
      map_latch <= '0;
      for (int i = 0; i < NUM_MSI; i++) map_target[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MSI; i++) begin
        if (wr_map && int'(wr_idx) == i) begin
          map_valid[i]  <= wr_valid_bit;
          map_target[i] <= wr_target;
        end
        // an acceptance in the same cycle wins over a release
        if (set_latch && int'(set_num) == i)
          map_latch[i] <= 1'b1;
        else if (wr_rel && wr_rel_bit && int'(wr_idx) == i)
          map_latch[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/msiq_queue.sv
module msiq_queue
  import msiq_pkg::*;
#(
  parameter int DEPTH_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_req,
  input  logic               wr_cset,
  input  logic               wr_cclr,
  input  logic               wr_tail,
  input  logic               wr_head,
  input  logic               wd_en,
  input  logic               wd_ovf,
  input  logic [DEPTH_W-1:0] wd_ptr,
  output logic               accept,
  output logic               drop_ovf,
  output logic [DEPTH_W-1:0] head,
  output logic [DEPTH_W-1:0] tail,
  output logic               en,
  output logic               ovf,
  output qstate_e            state,
  output logic               irq
);

  logic               full_w, eligible, disable_w, ovf_clr_w;
  logic [DEPTH_W-1:0] head_n, tail_n;
  qstate_e            state_n;

  assign full_w    = (tail + 1'b1) == head;
  assign eligible  = acc_req && en && (state != QS_ERROR);
  assign accept    = eligible && !full_w;
  assign drop_ovf  = eligible && full_w;
  assign disable_w = wr_cclr && wd_en;
  assign ovf_clr_w = wr_cclr && wd_ovf;

  assign head_n = wr_head ? wd_ptr : head;
  assign tail_n = wr_tail ? wd_ptr : (accept ? tail + 1'b1 : tail);

  always_comb begin
    state_n = state;
    if (drop_ovf)
      state_n = QS_ERROR;
    else if (disable_w)
      state_n = QS_IDLE;
    else begin
      case (state)
        QS_IDLE:   if (accept) state_n = QS_ACTIVE;
        QS_ACTIVE: if (head_n == tail_n) state_n = QS_IDLE;
        QS_ERROR:  if (ovf_clr_w) state_n = (head_n == tail_n) ? QS_IDLE : QS_ACTIVE;
        default:   state_n = QS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      en    <= 1'b0;
      ovf   <= 1'b0;
      state <= QS_IDLE;
    end else begin
      head  <= head_n;
      tail  <= tail_n;
      state <= state_n;
      if (disable_w)            en <= 1'b0;
      else if (wr_cset && wd_en) en <= 1'b1;
      if (drop_ovf)       ovf <= 1'b1;
      else if (ovf_clr_w) ovf <= 1'b0;
    end
  end

  assign irq = en && (head != tail);

endmodule

// File: rtl/msiq_ctrl.sv
module msiq_ctrl
  import msiq_pkg::*;
#(
  parameter int NUM_MSI = 16,
  parameter int NUM_Q   = 4,
  parameter int DEPTH_W = 7,
  localparam int MW  = $clog2(NUM_MSI),
  localparam int QIW = $clog2(NUM_Q),
  localparam int IW  = (MW > QIW) ? MW : QIW,
  localparam int AW  = IW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_valid,
  input  logic [15:0]        msi_num,
  input  logic [6:0]         msi_fmt,
  input  logic [9:0]         msi_len,
  input  logic [15:0]        msi_rid,
  input  logic [63:0]        msi_addr,
  input  logic [15:0]        msi_data1,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               ent_we,
  output logic [QIW-1:0]     ent_queue,
  output logic [DEPTH_W-1:0] ent_index,
  output logic [63:0]        ent_word0,
  output logic [63:0]        ent_word1,
  output logic [NUM_Q-1:0]   irq
);

  logic [2:0]    sp;
  logic [IW-1:0] idx;
  assign sp  = reg_addr[AW-1 -: 3];
  assign idx = reg_addr[IW-1:0];

  // named internal events, also used by the bound checker
  logic [NUM_MSI-1:0] map_valid, map_latch;
  logic [5:0]         map_target [NUM_MSI];
  logic [MW-1:0]      num_i;
  logic [5:0]         tgt;
  logic               msi_ok, any_accept;
  logic [NUM_Q-1:0]   q_accept, q_drop, q_en, q_ovf;
  logic [DEPTH_W-1:0] q_head [NUM_Q];
  logic [DEPTH_W-1:0] q_tail [NUM_Q];
  qstate_e            q_state [NUM_Q];
  logic [NUM_Q*3-1:0] q_state_flat;

  assign num_i  = msi_num[MW-1:0];
  assign tgt    = map_target[num_i];
  assign msi_ok = msi_valid && (int'(msi_num) < NUM_MSI) && is_msi_type(msi_fmt)
                  && map_valid[num_i] && !map_latch[num_i] && (int'(tgt) < NUM_Q);
  assign any_accept = |q_accept;

  msiq_map_table #(.NUM_MSI(NUM_MSI), .IW(IW), .MW(MW)) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_map(reg_wr && sp == SP_MAP),
    .wr_rel(reg_wr && sp == SP_REL),
    .wr_idx(idx),
    .wr_valid_bit(reg_wdata[B_VALID]),
    .wr_target(reg_wdata[5:0]),
    .wr_rel_bit(reg_wdata[B_LATCH]),
    .set_latch(any_accept),
    .set_num(num_i),
    .map_valid(map_valid),
    .map_latch(map_latch),
    .map_target(map_target)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic sel;
    assign sel = reg_wr && (int'(idx) == q);
    msiq_queue #(.DEPTH_W(DEPTH_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .acc_req(msi_ok && int'(tgt) == q),
      .wr_cset(sel && sp == SP_CSET),
      .wr_cclr(sel && sp == SP_CCLR),
      .wr_tail(sel && sp == SP_TAIL),
      .wr_head(sel && sp == SP_HEAD),
      .wd_en(reg_wdata[B_EN]),
      .wd_ovf(reg_wdata[B_OVF]),
      .wd_ptr(reg_wdata[DEPTH_W-1:0]),
      .accept(q_accept[q]),
      .drop_ovf(q_drop[q]),
      .head(q_head[q]),
      .tail(q_tail[q]),
      .en(q_en[q]),
      .ovf(q_ovf[q]),
      .state(q_state[q]),
      .irq(irq[q])
    );
    assign q_state_flat[q*3 +: 3] = q_state[q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_we    <= 1'b0;
      ent_queue <= '0;
      ent_index <= '0;
      ent_word0 <= '0;
      ent_word1 <= '0;
    end else begin
      ent_we <= any_accept;
      if (any_accept) begin
        ent_queue <= tgt[QIW-1:0];
        ent_index <= q_tail[tgt[QIW-1:0]];
        ent_word0 <= pack_word0(msi_fmt, msi_len, msi_addr[15:2], msi_rid, msi_num);
        ent_word1 <= pack_word1(msi_addr[63:16], msi_data1);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sp)
      SP_MAP: if (int'(idx) < NUM_MSI) begin
        reg_rdata[B_VALID] = map_valid[idx[MW-1:0]];
        reg_rdata[B_LATCH] = map_latch[idx[MW-1:0]];
        reg_rdata[5:0]     = map_target[idx[MW-1:0]];
      end
      SP_CSET, SP_CCLR: if (int'(idx) < NUM_Q) begin
        reg_rdata[B_EN]  = q_en[idx[QIW-1:0]];
        reg_rdata[B_OVF] = q_ovf[idx[QIW-1:0]];
      end
      SP_STATE: if (int'(idx) < NUM_Q) reg_rdata[2:0] = q_state[idx[QIW-1:0]];
      SP_TAIL: if (int'(idx) < NUM_Q) begin
        reg_rdata[B_OVF]       = q_ovf[idx[QIW-1:0]];
        reg_rdata[DEPTH_W-1:0] = q_tail[idx[QIW-1:0]];
      end
      SP_HEAD: if (int'(idx) < NUM_Q) reg_rdata[DEPTH_W-1:0] = q_head[idx[QIW-1:0]];
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/msiq_checks.sv
module msiq_checks #(
  parameter int NUM_MSI = 16,
  parameter int NUM_Q   = 4,
  parameter int MW      = 4,
  parameter int QIW     = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msi_valid,
  input logic [15:0]        msi_num,
  input logic               ent_we,
  input logic [QIW-1:0]     ent_queue,
  input logic [63:0]        ent_word0,
  input logic [NUM_MSI-1:0] map_valid,
  input logic [NUM_MSI-1:0] map_latch,
  input logic [NUM_Q-1:0]   q_en,
  input logic [NUM_Q-1:0]   q_ovf,
  input logic [NUM_Q*3-1:0] q_state_flat
);

  logic [NUM_Q-1:0] en_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_prev <= '0;
    else        en_prev <= q_en;

  // latched MSI never produces an entry
  p_dup_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && int'(msi_num) < NUM_MSI && map_latch[msi_num[MW-1:0]]) |=> !ent_we);

  // unmapped MSI never produces an entry
  p_unmapped_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && int'(msi_num) < NUM_MSI && !map_valid[msi_num[MW-1:0]]) |=> !ent_we);

  // an emitted entry leaves its latch set
  p_latch_after_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |-> map_latch[ent_word0[MW-1:0]]);

  // entries only go to queues that were enabled
  p_entry_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |-> en_prev[ent_queue]);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_qa
    p_state_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(q_state_flat[q*3 +: 3]) == 1);
    p_ovf_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_ovf[q]) |-> q_state_flat[q*3 +: 3] == 3'b100);
  end

endmodule

bind msiq_ctrl msiq_checks #(.NUM_MSI(NUM_MSI), .NUM_Q(NUM_Q), .MW(MW), .QIW(QIW)) u_checks (
  .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_num(msi_num),
  .ent_we(ent_we), .ent_queue(ent_queue), .ent_word0(ent_word0),
  .map_valid(map_valid), .map_latch(map_latch), .q_en(q_en), .q_ovf(q_ovf),
  .q_state_flat(q_state_flat)
);

// File: tb/sim_msiq_ctrl.sv
module sim_msiq_ctrl;

  localparam int NQ = 4;
  localparam int NM = 16;
  localparam int RING = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic [15:0] msi_num = '0;
  logic [6:0]  msi_fmt = '0;
  logic [9:0]  msi_len = '0;
  logic [15:0] msi_rid = '0;
  logic [63:0] msi_addr = '0;
  logic [15:0] msi_data1 = '0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        ent_we;
  logic [1:0]  ent_queue;
  logic [6:0]  ent_index;
  logic [63:0] ent_word0, ent_word1;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  int tl [NQ];
  int hd [NQ];
  bit done = 0;

  always #5 clk = ~clk;

  msiq_ctrl u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sp, input int idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'((sp << 4) | idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int sp, input int idx, output logic [63:0] d);
    @(negedge clk);
    reg_addr = 7'((sp << 4) | idx);
    #1 d = reg_rdata;
  endtask

  // drive one write, return entry outputs seen one cycle later
  task automatic send(input int num, input logic [6:0] fmt, output logic we,
                      output logic [63:0] w0, output logic [63:0] w1);
    @(negedge clk);
    msi_valid = 1'b1; msi_num = 16'(num); msi_fmt = fmt;
    msi_len = 10'(num * 3 + 1); msi_rid = 16'h4200 + 16'(num);
    msi_addr = {32'hBEEF_0000 + 32'(num), 32'h0000_1000 + 32'(num * 4)};
    msi_data1 = 16'h7700 + 16'(num);
    @(negedge clk);
    msi_valid = 1'b0;
    we = ent_we; w0 = ent_word0; w1 = ent_word1;
  endtask

  function automatic logic [63:0] exp_w0(input int num, input logic [6:0] fmt);
    logic [63:0] a;
    a = {32'hBEEF_0000 + 32'(num), 32'h0000_1000 + 32'(num * 4)};
    return (64'(fmt) << 56) | (64'(num * 3 + 1) << 46) | (((a >> 2) & 64'h3fff) << 32)
         | (64'(16'h4200 + 16'(num)) << 16) | 64'(num);
  endfunction

  function automatic logic [63:0] exp_w1(input int num);
    logic [63:0] a;
    a = {32'hBEEF_0000 + 32'(num), 32'h0000_1000 + 32'(num * 4)};
    return (a & 64'hFFFF_FFFF_FFFF_0000) | 64'(16'h7700 + 16'(num));
  endfunction

  // send and check one expected acceptance
  task automatic expect_entry(input string req, input int num, input logic [6:0] fmt, input int q);
    logic we; logic [63:0] w0, w1;
    send(num, fmt, we, w0, w1);
    chk(req, 64'(we), 64'd1);
    chk(req, 64'(ent_queue), 64'(q));
    chk(req, 64'(ent_index), 64'(tl[q]));
    chk(req, w0, exp_w0(num, fmt));
    chk(req, w1, exp_w1(num));
    tl[q] = (tl[q] + 1) % RING;
  endtask

  task automatic expect_none(input string req, input int num, input logic [6:0] fmt);
    logic we; logic [63:0] w0, w1;
    send(num, fmt, we, w0, w1);
    chk(req, 64'(we), 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    for (int q = 0; q < NQ; q++) begin tl[q] = 0; hd[q] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int q = 0; q < NQ; q++) begin
      rd(4, q, d); chk("R1 state", d, 64'd1);
      rd(5, q, d); chk("R1 tail", d, 64'd0);
      rd(6, q, d); chk("R1 head", d, 64'd0);
      rd(2, q, d); chk("R1 ctl", d, 64'd0);
    end
    rd(0, 3, d); chk("R1 map", d, 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 ent_we", 64'(ent_we), 64'd0);

    // R10 map all MSIs, enable all queues
    for (int i = 0; i < NM; i++) wr(0, i, (64'd1 << 63) | 64'(i % NQ));
    rd(0, 7, d); chk("R10 map readback", d, (64'd1 << 63) | 64'd3);
    for (int q = 0; q < NQ; q++) wr(2, q, 64'd1 << 44);
    rd(2, 1, d); chk("R7 enable readback", d, 64'd1 << 44);

    // R3 R5 sweep of all MSIs, both MSI types
    for (int i = 0; i < NM; i++)
      expect_entry("R3 sweep", i, ((i % 2) != 0) ? (7'h78 | 7'(i & 7)) : (7'h58 | 7'(i & 7)), i % NQ);
    for (int q = 0; q < NQ; q++) begin
      rd(4, q, d); chk("R8 active", d, 64'd2);
      rd(5, q, d); chk("R5 tail", d, 64'(tl[q]));
    end
    chk("R9 irq all", 64'(irq), 64'hf);

    // R4 duplicates suppressed
    for (int i = 0; i < NM; i++) expect_none("R4 duplicate", i, 7'h58);
    rd(0, 3, d); chk("R4 latch readback", d, (64'd3 << 62) | 64'd3);

    // R2 type filtering, R4 release
    wr(1, 0, 64'd1 << 62);
    rd(0, 0, d); chk("R4 released", d, 64'd1 << 63);
    expect_none("R2 message type", 0, 7'h30);
    expect_none("R2 empty type", 0, 7'h00);
    expect_entry("R4 after release", 0, 7'h5b, 0);

    // R2 invalid map, target out of range, number out of range
    wr(0, 5, 64'd0); wr(1, 5, 64'd1 << 62);
    expect_none("R2 invalid map", 5, 7'h58);
    wr(0, 6, (64'd1 << 63) | 64'd9); wr(1, 6, 64'd1 << 62);
    expect_none("R2 target range", 6, 7'h58);
    expect_none("R2 num range", 20, 7'h58);

    // R7 disable
    wr(3, 3, 64'd1 << 44);
    rd(4, 3, d); chk("R7 disabled idle", d, 64'd1);
    chk("R9 irq disabled", 64'(irq[3]), 64'd0);
    wr(1, 7, 64'd1 << 62);
    expect_none("R7 disabled queue", 7, 7'h58);

    // R8 head catches tail
    wr(6, 0, 64'(tl[0])); hd[0] = tl[0];
    rd(4, 0, d); chk("R8 idle again", d, 64'd1);
    chk("R9 irq cleared", 64'(irq[0]), 64'd0);
    wr(6, 1, 64'(tl[1] - 1)); hd[1] = tl[1] - 1;
    rd(4, 1, d); chk("R8 still active", d, 64'd2);
    chk("R9 irq partial", 64'(irq[1]), 64'd1);

    // R5 R6 ring wrap and overflow on queue 2
    wr(5, 2, 64'd5); wr(6, 2, 64'd5); tl[2] = 5; hd[2] = 5;
    rd(4, 2, d); chk("R8 idle after ptr writes", d, 64'd1);
    for (int k = 0; k < RING - 1; k++) begin
      wr(1, 2, 64'd1 << 62);
      expect_entry("R5 wrap", 2, 7'h58, 2);
    end
    wr(1, 2, 64'd1 << 62);
    expect_none("R6 overflow drop", 2, 7'h58);
    rd(5, 2, d); chk("R6 tail ovf", d, (64'd1 << 57) | 64'd4);
    rd(4, 2, d); chk("R6 error state", d, 64'd4);
    rd(0, 2, d); chk("R6 latch clear", d, (64'd1 << 63) | 64'd2);
    expect_none("R6 error blocks", 2, 7'h58);
    chk("R9 irq in error", 64'(irq[2]), 64'd1);

    // R7 overflow clear
    wr(3, 2, 64'd1 << 57);
    rd(4, 2, d); chk("R7 error to active", d, 64'd2);
    rd(3, 2, d); chk("R7 ovf cleared", d, 64'd1 << 44);
    wr(6, 2, 64'(tl[2]));
    rd(4, 2, d); chk("R8 idle after catch", d, 64'd1);
    chk("R9 irq after catch", 64'(irq[2]), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule